// File: doc/BRIEF.md
# Twin-Port Synchronous Static Memory with Per-Port Output Latency

This block is a true dual-port synchronous memory of `DW`-bit words (9 by default) with `2**AW` locations. Each port runs on its own clock and has an address, write data, a read/write select, an active-low enable, an active-high enable, an asynchronous active-low output enable and a static latency mode pin. Address, data and control are taken on the rising edge of the port clock. Both ports may reach any word, including the same word, at any time.

A read becomes visible either one edge after the address is taken (flow-through) or one edge later still (pipelined). The mode is chosen per port by a static pin, so the two ports may run in different modes. In place of a tri-state bus, each port drives a `drive` flag that is high when its read data is valid and the output would be enabled. `rdata` is zero whenever `drive` is low.

In pipelined mode the port selection passes through two register stages, so the output turns on two edges after a selected read and stays on for one edge after a deselect. If both ports write the same word on the same edge, port A's data is kept.

Top module: `twin_port_sram`

## Requirements
- R1: A port is selected on an edge only when its `en_n` is 0 and its `en` is 1. On any other combination the edge neither writes memory nor produces a read, and `drive` is low for the following cycle.
- R2: On an edge where the port is selected and `rw` is 0, `wdata` is stored at `addr`. `rw` = 1 selects a read.
- R3: With `pipe` = 0, a selected read taken on edge k raises `drive` after edge k, and `rdata` holds the word at that address until edge k+1.
- R4: With `pipe` = 1, a selected read taken on edge k gives `drive` high and the data after edge k+1. The output stays on for one edge after the port is deselected and turns off after the second.
- R5: `oe_n` = 1 forces `drive` low and `rdata` to zero at once, without waiting for a clock edge. Returning it to 0 restores the pending output at once.
- R6: Writes never raise `drive`. While `drive` is low, `rdata` is zero.
- R7: A word written by one port is returned by a read on the other port taken on the same edge or on any later edge (common clock).
- R8: When both ports write the same address on the same edge, the word afterwards holds port A's data.
- R9: While a port's `rst_n` is low, its `drive` is low and `rdata` is zero.
- R10: Each port's latency follows only its own `pipe` pin. One port may be pipelined while the other is flow-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_en_n | input | 1 | Port A enable, active low |
| a_en | input | 1 | Port A enable, active high |
| a_rw | input | 1 | Port A 1 = read, 0 = write |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A latency mode, 1 = pipelined, 0 = flow-through |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, zero when not driving |
| a_drive | output | 1 | Port A read data valid and enabled |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_en_n | input | 1 | Port B enable, active low |
| b_en | input | 1 | Port B enable, active high |
| b_rw | input | 1 | Port B 1 = read, 0 = write |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B latency mode, 1 = pipelined, 0 = flow-through |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, zero when not driving |
| b_drive | output | 1 | Port B read data valid and enabled |

## Verification
The hardest cases to reach are those that need both ports to act on exactly the same edge: a same-address write collision, and a write on one port with a read of that word on the other. The bench drives both port clocks from one clock, so that each vector in its table lands on both ports at a single edge. Two further cases are checked in directed sequences. One is the two-edge turn-off of a pipelined port after a deselect. The other is an asynchronous output-enable change made in the middle of a cycle.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

  function automatic logic port_selected(input logic en_n, input logic en);
    return (!en_n) && en;
  endfunction
endpackage

// File: rtl/tps_store.sv
module tps_store #(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          clk0,
  input  logic          rst0_n,
  input  logic          wr0,
  input  logic [AW-1:0] waddr0,
  input  logic [DW-1:0] wdata0,
  input  logic [AW-1:0] raddr0,
  output logic [DW-1:0] rword0,
  input  logic          clk1,
  input  logic          rst1_n,
  input  logic          wr1,
  input  logic [AW-1:0] waddr1,
  input  logic [DW-1:0] wdata1,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rword1
);
  localparam int DEPTH = 1 << AW;

  // One bank per writing clock; owner bits select the latest bank per word.
  logic [DW-1:0] bank0 [DEPTH];
  logic [DW-1:0] bank1 [DEPTH];
  logic [DEPTH-1:0] own0;
  logic [DEPTH-1:0] own1;

  logic wr1_ok;
  assign wr1_ok = wr1 && !(wr0 && (waddr0 == waddr1));

  always_ff @(posedge clk0) begin
    if (wr0) bank0[waddr0] <= wdata0;
  end

  always_ff @(posedge clk0 or negedge rst0_n) begin
    if (!rst0_n)  own0 <= '0;
    else if (wr0) own0[waddr0] <= own1[waddr0];
  end

  always_ff @(posedge clk1) begin
    if (wr1_ok) bank1[waddr1] <= wdata1;
  end

  always_ff @(posedge clk1 or negedge rst1_n) begin
    if (!rst1_n)     own1 <= '0;
    else if (wr1_ok) own1[waddr1] <= ~own0[waddr1];
  end

  assign rword0 = (own0[raddr0] == own1[raddr0]) ? bank0[raddr0] : bank1[raddr0];
  assign rword1 = (own0[raddr1] == own1[raddr1]) ? bank0[raddr1] : bank1[raddr1];
endmodule

// File: rtl/tps_port.sv
module tps_port
  import tps_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          en,
  input  logic          rw,
  input  logic          oe_n,
  input  logic          pipe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] rdata,
  output logic          drive
);
  logic          sel;
  logic          rd_s1;
  logic          rd_s2;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          stage_ok;
  logic [DW-1:0] stage_data;

  assign sel     = port_selected(en_n, en);
  assign wr_req  = sel && !rw;
  assign wr_addr = addr;
  assign wr_data = wdata;
  assign rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_s1  <= 1'b0;
      rd_s2  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      rd_s1  <= sel && rw;
      rd_s2  <= rd_s1;
      addr_q <= addr;
      if (rd_s1) data_q <= rd_word;
    end
  end

  always_comb begin
    if (out_mode_e'(pipe) == OUT_PIPE) begin
      stage_ok   = rd_s2;
      stage_data = data_q;
    end else begin
      stage_ok   = rd_s1;
      stage_data = rd_word;
    end
  end

  assign drive = stage_ok && !oe_n;
  assign rdata = drive ? stage_data : '0;
endmodule

// File: rtl/twin_port_sram.sv
module twin_port_sram #(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic          a_en_n,
  input  logic          a_en,
  input  logic          a_rw,
  input  logic          a_oe_n,
  input  logic          a_pipe,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_drive,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic          b_en_n,
  input  logic          b_en,
  input  logic          b_rw,
  input  logic          b_oe_n,
  input  logic          b_pipe,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_drive
);
  localparam int NP = 2;

  logic          clk_v   [NP];
  logic          rst_v   [NP];
  logic          en_n_v  [NP];
  logic          en_v    [NP];
  logic          rw_v    [NP];
  logic          oe_n_v  [NP];
  logic          pipe_v  [NP];
  logic [AW-1:0] addr_v  [NP];
  logic [DW-1:0] wd_v    [NP];
  logic          wreq_v  [NP];
  logic [AW-1:0] waddr_v [NP];
  logic [DW-1:0] wdat_v  [NP];
  logic [AW-1:0] raddr_v [NP];
  logic [DW-1:0] rword_v [NP];
  logic [DW-1:0] rdata_v [NP];
  logic          drive_v [NP];

  assign clk_v[0] = a_clk;    assign clk_v[1] = b_clk;
  assign rst_v[0] = a_rst_n;  assign rst_v[1] = b_rst_n;
  assign en_n_v[0] = a_en_n;  assign en_n_v[1] = b_en_n;
  assign en_v[0] = a_en;      assign en_v[1] = b_en;
  assign rw_v[0] = a_rw;      assign rw_v[1] = b_rw;
  assign oe_n_v[0] = a_oe_n;  assign oe_n_v[1] = b_oe_n;
  assign pipe_v[0] = a_pipe;  assign pipe_v[1] = b_pipe;
  assign addr_v[0] = a_addr;  assign addr_v[1] = b_addr;
  assign wd_v[0] = a_wdata;   assign wd_v[1] = b_wdata;

  for (genvar p = 0; p < NP; p++) begin : g_port
    tps_port #(.AW(AW), .DW(DW)) u_port (
      .clk     (clk_v[p]),
      .rst_n   (rst_v[p]),
      .en_n    (en_n_v[p]),
      .en      (en_v[p]),
      .rw      (rw_v[p]),
      .oe_n    (oe_n_v[p]),
      .pipe    (pipe_v[p]),
      .addr    (addr_v[p]),
      .wdata   (wd_v[p]),
      .wr_req  (wreq_v[p]),
      .wr_addr (waddr_v[p]),
      .wr_data (wdat_v[p]),
      .rd_addr (raddr_v[p]),
      .rd_word (rword_v[p]),
      .rdata   (rdata_v[p]),
      .drive   (drive_v[p])
    );
  end

  tps_store #(.AW(AW), .DW(DW)) u_store (
    .clk0   (clk_v[0]),
    .rst0_n (rst_v[0]),
    .wr0    (wreq_v[0]),
    .waddr0 (waddr_v[0]),
    .wdata0 (wdat_v[0]),
    .raddr0 (raddr_v[0]),
    .rword0 (rword_v[0]),
    .clk1   (clk_v[1]),
    .rst1_n (rst_v[1]),
    .wr1    (wreq_v[1]),
    .waddr1 (waddr_v[1]),
    .wdata1 (wdat_v[1]),
    .raddr1 (raddr_v[1]),
    .rword1 (rword_v[1])
  );

  assign a_rdata = rdata_v[0];
  assign a_drive = drive_v[0];
  assign b_rdata = rdata_v[1];
  assign b_drive = drive_v[1];
endmodule

// File: rtl/twin_port_sram_chk.sv
module twin_port_sram_chk #(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input logic          a_clk,
  input logic          a_rst_n,
  input logic          a_en_n,
  input logic          a_en,
  input logic          a_rw,
  input logic          a_oe_n,
  input logic          a_pipe,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          a_drive,
  input logic          b_clk,
  input logic          b_rst_n,
  input logic          b_en_n,
  input logic          b_en,
  input logic          b_rw,
  input logic          b_oe_n,
  input logic          b_pipe,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic          b_drive
);
  logic a_rd, b_rd, a_quiet;
  assign a_rd    = !a_en_n && a_en && a_rw;
  assign b_rd    = !b_en_n && b_en && b_rw;
  assign a_quiet = a_en_n || !a_en || !a_rw;

  // R3: flow-through read drives after the next edge unless disabled
  a_r3_flow_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (!a_pipe && a_rd) |=> (a_drive || a_oe_n || a_pipe));
  a_r3_flow_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (!b_pipe && b_rd) |=> (b_drive || b_oe_n || b_pipe));

  // R4: pipelined read drives two edges later
  a_r4_pipe_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (a_pipe && a_rd) ##1 a_pipe |=> (a_drive || a_oe_n || !a_pipe));

  // R1, R6: no selected read means no drive in flow-through mode
  a_r6_quiet_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (!a_pipe && a_quiet) |=> (!a_drive || a_pipe));

  // R4: pipelined port stays quiet two edges after two non-reads
  a_r4_off_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (a_pipe && a_quiet) ##1 (a_pipe && a_quiet) |=> (!a_drive || !a_pipe));

  // R5, R9: immediate conditions on port A
  always_comb begin
    if (a_oe_n) a_r5_oe_off: assert (!a_drive || !a_rst_n);
    if (!a_rst_n) a_r9_reset_quiet: assert (!a_drive);
  end
endmodule

bind twin_port_sram twin_port_sram_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/twin_port_sram_bench.sv
module twin_port_sram_bench;
  localparam int AW = 9;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en_n, a_en, a_rw, a_oe_n, a_pipe;
  logic b_en_n, b_en, b_rw, b_oe_n, b_pipe;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_drive, b_drive;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  twin_port_sram #(.AW(AW), .DW(DW)) u_twin_port_sram (
    .a_clk(clk), .a_rst_n(rst_n), .a_en_n(a_en_n), .a_en(a_en), .a_rw(a_rw),
    .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_drive(a_drive),
    .b_clk(clk), .b_rst_n(rst_n), .b_en_n(b_en_n), .b_en(b_en), .b_rw(b_rw),
    .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_drive(b_drive)
  );

  // cmd: 0 = deselect, 1 = write, 2 = read
  typedef struct packed {
    logic [1:0]    a_cmd;
    logic [AW-1:0] a_ad;
    logic [DW-1:0] a_d;
    logic [1:0]    b_cmd;
    logic [AW-1:0] b_ad;
    logic [DW-1:0] b_d;
    logic          ea_drv;
    logic [DW-1:0] ea_q;
    logic          eb_drv;
    logic [DW-1:0] eb_q;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 9'd5, 9'h1A5, 2'd1, 9'd9, 9'h0F3, 1'b0, 9'h000, 1'b0, 9'h000},
    '{2'd2, 9'd9, 9'h000, 2'd2, 9'd5, 9'h000, 1'b1, 9'h0F3, 1'b1, 9'h1A5},
    '{2'd1, 9'd9, 9'h155, 2'd2, 9'd9, 9'h000, 1'b0, 9'h000, 1'b1, 9'h155},
    '{2'd1, 9'd7, 9'h011, 2'd1, 9'd7, 9'h122, 1'b0, 9'h000, 1'b0, 9'h000},
    '{2'd2, 9'd7, 9'h000, 2'd2, 9'd7, 9'h000, 1'b1, 9'h011, 1'b1, 9'h011},
    '{2'd0, 9'd5, 9'h000, 2'd2, 9'd5, 9'h000, 1'b0, 9'h000, 1'b1, 9'h1A5}
  };

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_a(input logic [1:0] cmd, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    a_en_n = (cmd == 2'd0); a_en = 1'b1; a_rw = (cmd != 2'd1); a_addr = ad; a_wdata = d;
  endtask

  task automatic set_b(input logic [1:0] cmd, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    b_en_n = (cmd == 2'd0); b_en = 1'b1; b_rw = (cmd != 2'd1); b_addr = ad; b_wdata = d;
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    a_oe_n = 1'b0; b_oe_n = 1'b0; a_pipe = 1'b0; b_pipe = 1'b0;
    set_a(2'd2, '0, '0); set_b(2'd2, '0, '0);
    repeat (3) tick;
    // R9: reset holds outputs quiet even with reads requested
    chk("R9 a_drive in reset", {a_drive, a_rdata}, '0);
    chk("R9 b_drive in reset", {b_drive, b_rdata}, '0);
    set_a(2'd0, '0, '0); set_b(2'd0, '0, '0);
    rst_n = 1'b1;
    tick;

    // R2 R3 R6 R7 R8: table walk, both ports flow-through on one clock
    for (int i = 0; i < NV; i++) begin
      set_a(TBL[i].a_cmd, TBL[i].a_ad, TBL[i].a_d);
      set_b(TBL[i].b_cmd, TBL[i].b_ad, TBL[i].b_d);
      tick;
      chk($sformatf("R3/R6/R7/R8 vec %0d port A", i), {a_drive, a_rdata}, {TBL[i].ea_drv, TBL[i].ea_q});
      chk($sformatf("R3/R6/R7/R8 vec %0d port B", i), {b_drive, b_rdata}, {TBL[i].eb_drv, TBL[i].eb_q});
    end
    set_b(2'd0, '0, '0);

    // R5: asynchronous output enable during a flow-through read
    set_a(2'd2, 9'd5, '0);
    tick;
    chk("R5 before oe change", {a_drive, a_rdata}, {1'b1, 9'h1A5});
    a_oe_n = 1'b1; #1;
    chk("R5 oe_n high mid-cycle", {a_drive, a_rdata}, '0);
    a_oe_n = 1'b0; #1;
    chk("R5 oe_n low restores", {a_drive, a_rdata}, {1'b1, 9'h1A5});

    // R1: invalid enable combinations neither read nor write
    a_en_n = 1'b1; a_en = 1'b1; a_rw = 1'b1;
    tick;
    chk("R1 en_n high blocks read", {1'b0, a_drive}, 10'd0);
    a_en_n = 1'b0; a_en = 1'b0; a_rw = 1'b0; a_addr = 9'd5; a_wdata = 9'h0AA;
    tick;
    chk("R1 en low blocks write (drive)", {1'b0, a_drive}, 10'd0);
    set_a(2'd2, 9'd5, '0);
    tick;
    chk("R1 word 5 unchanged", {a_drive, a_rdata}, {1'b1, 9'h1A5});

    // R4 R10: A pipelined, B flow-through, reading the same word
    a_pipe = 1'b1;
    set_a(2'd0, '0, '0);
    tick;
    tick;
    set_a(2'd2, 9'd9, '0); set_b(2'd2, 9'd9, '0);
    tick;
    chk("R4 pipelined no drive after one edge", {a_drive, a_rdata}, '0);
    chk("R10 flow port drives after one edge", {b_drive, b_rdata}, {1'b1, 9'h155});
    set_a(2'd2, 9'd7, '0); set_b(2'd0, '0, '0);
    tick;
    chk("R4 pipelined data after two edges", {a_drive, a_rdata}, {1'b1, 9'h155});
    set_a(2'd0, '0, '0);
    tick;
    chk("R4 second pipelined word, deselected", {a_drive, a_rdata}, {1'b1, 9'h011});
    tick;
    chk("R4 output off two edges after deselect", {a_drive, a_rdata}, '0);

    // R6: a pipelined write does not drive
    set_a(2'd1, 9'd3, 9'h07E);
    tick;
    set_a(2'd0, '0, '0);
    tick;
    chk("R6 pipelined write no drive", {a_drive, a_rdata}, '0);
    set_b(2'd2, 9'd3, '0);
    tick;
    chk("R2 write visible on port B", {b_drive, b_rdata}, {1'b1, 9'h07E});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule